// File: doc/BRIEF.md
# Proportional-Integral Varactor Controller

This block sits between a three-state phase-frequency detector and a switched-capacitor oscillator in an all-digital PLL. Once per divided feedback clock it captures the detector's UP and DN levels in retiming flops. From those flops it drives two separate capacitor-enable groups. The proportional group gets a two-bit code meaning -1, 0 or +1. The integral group gets a word that steps one capacitor position at a time toward higher or lower tuning.

The two contributions are never added in logic. Each group switches its own capacitors, and the capacitor array does the summing. A parameter picks the integral coding. The default is a bidirectional thermometer shift register, whose word is always a contiguous run of ones from bit 0. The alternative is a binary up/down counter over the same range. In both codings the integral state saturates at its ends and never wraps.

Top module: `varcap_pi_ctrl`

## Requirements
- R1: While `rst` is high at a rising `fb_clk` edge, the retimed inputs clear, `prop_code` becomes 01 and the integral state loads half its range. In the default thermometer mode with width 16, `integ_word` is 16'h00FF.
- R2: After each rising edge, `prop_code` reflects the UP/DN levels sampled at that edge. The encoding is UP=0/DN=0 → 01 (zero), UP=0/DN=1 → 00 (minus one), UP=1/DN=0 → 10 (plus one), UP=1/DN=1 → 01 (zero).
- R3: A sample with UP=1 and DN=0 raises the integral level by one, one edge after the sample is taken. In thermometer mode a 1 enters at bit 0 and the existing ones shift up one place.
- R4: A sample with UP=0 and DN=1 lowers the integral level by one, one edge after the sample is taken. In thermometer mode the highest 1 is removed.
- R5: A sample with UP and DN both 0, or both 1, leaves the integral word unchanged on the following edge.
- R6: At the full level (all ones in thermometer mode), further UP samples leave the word at full.
- R7: At level zero (all zeros), further DN samples leave the word at zero.
- R8: In thermometer mode, `integ_word` is always of the form 2^n-1 for some n from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fb_clk | input | 1 | Divided feedback clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_in | input | 1 | UP level from the phase-frequency detector |
| dn_in | input | 1 | DN level from the phase-frequency detector |
| prop_code | output | 2 | Proportional capacitor enables (00 = -1, 01 = 0, 10 = +1) |
| integ_word | output | 16 | Integral capacitor enables (thermometer, or zero-extended binary count) |

## Verification
The hardest states to reach are the two saturation limits. Reaching either one from reset takes at least eight consecutive samples in one direction. Evenly weighted random UP/DN would only drift around the midpoint. The stimulus therefore mixes biased random phases with directed runs of twenty UP and then twenty DN samples. These runs pin the word against each end and test that it holds there. Random phases also include UP=DN=1 samples, which check that the overlap case behaves like the locked case in both paths.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;

    typedef enum logic [1:0] {
        PROP_MINUS = 2'b00,
        PROP_ZERO  = 2'b01,
        PROP_PLUS  = 2'b10
    } prop_e;

    typedef enum logic {
        MODE_THERM = 1'b0,
        MODE_COUNT = 1'b1
    } int_mode_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pd_sample_s;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10
    } step_e;

    function automatic prop_e prop_of(pd_sample_s s);
        case ({s.up, s.dn})
            2'b10:   return PROP_PLUS;
            2'b01:   return PROP_MINUS;
            default: return PROP_ZERO;
        endcase
    endfunction

    function automatic step_e step_of(pd_sample_s s);
        case ({s.up, s.dn})
            2'b10:   return STEP_INC;
            2'b01:   return STEP_DEC;
            default: return STEP_HOLD;
        endcase
    endfunction

endpackage

// File: rtl/pd_retime.sv
module pd_retime
    import pi_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       up_in,
    input  logic       dn_in,
    output pd_sample_s smp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else begin
            smp.up <= up_in;
            smp.dn <= dn_in;
        end
    end

endmodule

// File: rtl/prop_path.sv
module prop_path
    import pi_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pd_sample_s smp,
    output logic [1:0] prop_code
);

    prop_e code;

    always_comb code = prop_of(smp);

    assign prop_code = code;

    // R2
    prop_legal_chk: assert property (@(posedge clk) disable iff (rst)
        prop_code != 2'b11);

    // R2
    prop_overlap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (smp.up && smp.dn) |-> prop_code == 2'b01);

endmodule

// File: rtl/integ_path.sv
module integ_path
    import pi_ctrl_pkg::*;
#(
    parameter int        WIDTH = 16,
    parameter int_mode_e MODE  = MODE_THERM,
    localparam int       LW    = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  pd_sample_s       smp,
    output logic [WIDTH-1:0] word,
    output logic [LW-1:0]    level
);

    localparam int HALF = WIDTH / 2;

    step_e step;

    always_comb step = step_of(smp);

    generate
        if (MODE == MODE_THERM) begin : g_therm
            logic [WIDTH-1:0] sr;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= WIDTH'((WIDTH + 1)'(1) << HALF) - WIDTH'(1);
                end else begin
                    case (step)
                        STEP_INC: sr <= {sr[WIDTH-2:0], 1'b1};
                        STEP_DEC: sr <= {1'b0, sr[WIDTH-1:1]};
                        default:  sr <= sr;
                    endcase
                end
            end

            assign word  = sr;
            assign level = LW'($countones(sr));

            // R8
            therm_contig_chk: assert property (@(posedge clk) disable iff (rst)
                ((sr & (sr + WIDTH'(1))) == '0));
        end else begin : g_count
            logic [LW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= LW'(HALF);
                end else begin
                    case (step)
                        STEP_INC: if (cnt < LW'(WIDTH)) cnt <= cnt + LW'(1);
                        STEP_DEC: if (cnt != '0) cnt <= cnt - LW'(1);
                        default:  cnt <= cnt;
                    endcase
                end
            end

            assign word  = WIDTH'(cnt);
            assign level = cnt;
        end
    endgenerate

    // R3
    integ_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (smp.up && !smp.dn && level < LW'(WIDTH)) |=> level == LW'($past(level) + LW'(1)));

    // R4
    integ_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp.up && smp.dn && level != '0) |=> level == LW'($past(level) - LW'(1)));

    // R5
    integ_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (smp.up == smp.dn) |=> $stable(word));

    // R6
    integ_top_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (smp.up && !smp.dn && level == LW'(WIDTH)) |=> level == LW'(WIDTH));

    // R7
    integ_bot_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!smp.up && smp.dn && level == '0) |=> level == '0);

endmodule

// File: rtl/varcap_pi_ctrl.sv
module varcap_pi_ctrl
    import pi_ctrl_pkg::*;
#(
    parameter int        WIDTH = 16,
    parameter int_mode_e MODE  = MODE_THERM
) (
    input  logic             fb_clk,
    input  logic             rst,
    input  logic             up_in,
    input  logic             dn_in,
    output logic [1:0]       prop_code,
    output logic [WIDTH-1:0] integ_word
);

    localparam int LW = $clog2(WIDTH + 1);

    pd_sample_s    smp;
    logic [LW-1:0] level;

    pd_retime u_retime (
        .clk   (fb_clk),
        .rst   (rst),
        .up_in (up_in),
        .dn_in (dn_in),
        .smp   (smp)
    );

    prop_path u_prop (
        .clk       (fb_clk),
        .rst       (rst),
        .smp       (smp),
        .prop_code (prop_code)
    );

    integ_path #(
        .WIDTH (WIDTH),
        .MODE  (MODE)
    ) u_integ (
        .clk   (fb_clk),
        .rst   (rst),
        .smp   (smp),
        .word  (integ_word),
        .level (level)
    );

    // R1
    reset_state_chk: assert property (@(posedge fb_clk)
        rst |=> (prop_code == 2'b01 && level == LW'(WIDTH / 2)));

endmodule

// File: tb/varcap_pi_ctrl_tb.sv
module varcap_pi_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         fb_clk = 1'b0;
    logic         rst    = 1'b1;
    logic         up_in  = 1'b0;
    logic         dn_in  = 1'b0;
    logic [1:0]   prop_code;
    logic [W-1:0] integ_word;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  lvl;
    bit  pu, pd;
    logic [1:0] exp_prop;

    always #(CLK_PERIOD / 2) fb_clk = ~fb_clk;

    varcap_pi_ctrl u_dut (
        .fb_clk     (fb_clk),
        .rst        (rst),
        .up_in      (up_in),
        .dn_in      (dn_in),
        .prop_code  (prop_code),
        .integ_word (integ_word)
    );

    function automatic logic [W-1:0] therm(int n);
        if (n >= W) return '1;
        return W'(((W + 1)'(1) << n) - (W + 1)'(1));
    endfunction

    function automatic logic [1:0] prop_exp(bit u, bit d);
        if (u && !d) return 2'b10;
        if (!u && d) return 2'b00;
        return 2'b01;
    endfunction

    function automatic bit contiguous(logic [W-1:0] v);
        return (v & (v + W'(1))) == '0;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle(bit u, bit d, string tag);
        int old;
        up_in = u;
        dn_in = d;
        @(posedge fb_clk);
        old = lvl;
        if (pu && !pd && lvl < W) lvl++;
        else if (!pu && pd && lvl > 0) lvl--;
        pu = u;
        pd = d;
        exp_prop = prop_exp(u, d);
        @(negedge fb_clk);
        check(prop_code == exp_prop, "R2 prop_code", 32'(prop_code), 32'(exp_prop));
        check(integ_word == therm(lvl), tag, 32'(integ_word), 32'(therm(lvl)));
        check(contiguous(integ_word), "R8 contiguity", 32'(integ_word), 32'(therm(lvl)));
        if (old == lvl && lvl == W)
            check(integ_word == '1, "R6 top saturation", 32'(integ_word), 32'hFFFF);
        if (old == lvl && lvl == 0)
            check(integ_word == '0, "R7 bottom saturation", 32'(integ_word), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        // R1 reset state
        up_in = 1'b1;
        repeat (3) @(posedge fb_clk);
        @(negedge fb_clk);
        check(prop_code == 2'b01, "R1 reset prop", 32'(prop_code), 32'h1);
        check(integ_word == 16'h00FF, "R1 reset integ", 32'(integ_word), 32'h00FF);
        up_in = 1'b0;
        rst = 1'b0;
        lvl = W / 2;
        pu = 1'b0;
        pd = 1'b0;
        // R2 directed truth table
        cycle(1'b0, 1'b0, "R5 hold zero");
        cycle(1'b0, 1'b1, "R5 hold");
        cycle(1'b1, 1'b0, "R4 decrement");
        cycle(1'b1, 1'b1, "R3 increment");
        cycle(1'b0, 1'b0, "R5 hold overlap");
        // R3 and R6: run up into the top
        for (int i = 0; i < 20; i++) cycle(1'b1, 1'b0, "R3 R6 up run");
        cycle(1'b1, 1'b1, "R6 top hold");
        // R4 and R7: run down into the bottom
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, "R4 R7 down run");
        cycle(1'b0, 1'b0, "R7 bottom hold");
        // random phases with drift bias
        for (int ph = 0; ph < 8; ph++) begin
            for (int i = 0; i < 60; i++) begin
                int r;
                bit u, d;
                r = int'($urandom_range(0, 99));
                if (ph % 2 == 0) begin
                    u = (r < 60);
                    d = (r >= 50);
                end else begin
                    u = (r >= 50 && r < 60) || (r >= 90);
                    d = (r < 60);
                end
                cycle(u, d, "R3 R4 R5 random");
            end
        end
        // R1 reset again from a non-default state
        up_in = 1'b0;
        dn_in = 1'b0;
        rst = 1'b1;
        @(posedge fb_clk);
        @(negedge fb_clk);
        check(integ_word == 16'h00FF, "R1 re-reset integ", 32'(integ_word), 32'h00FF);
        check(prop_code == 2'b01, "R1 re-reset prop", 32'(prop_code), 32'h1);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule